// File: doc/BRIEF.md
# Eight-Channel Compare/Capture Timer

The block is a timer peripheral built around one free-running 16-bit counter that all channels share. A divider in front of the counter makes it advance once every 2^p bus clocks, where p is a 3-bit field, and only while a run bit is set. Each of the eight channels has a 16-bit channel register and runs in one of two functions. In compare function, the channel watches the counter, and when the counter steps onto the channel's value it raises its flag and acts on its output pin. In capture function, a pulse on the channel's event input copies the counter into the channel register.

Software programs the block through a flat word-wide register port. Writes are synchronous and reads are combinational. The address map is: 0 control (bit 0 run, bit 1 quick-flag-clear, bits 4:2 prescale exponent), 1 function select, 2 pin actions of channels 7..4, 3 pin actions of channels 3..0, 4 interrupt enable, 5 flags, 6 counter (read only), and 8+n the register of channel n. The pin-action registers hold two bits per channel, with the highest channel of each group in the topmost pair. A typical use is to add a delay to the current count, write the sum to a channel, and reload the channel from its own previous value on each match to produce an exact periodic waveform.

Top module: `octimer_unit`

## Requirements
- R1: After reset every register reads 0, the counter is 0, and all pins, pin enables and interrupt outputs are 0.
- R2: The counter holds its value while control bit 0 (run) is 0.
- R3: While running with prescale exponent p (control bits 4:2), the counter advances by exactly one every 2^p bus clocks and wraps from 16'hFFFF to 0.
- R4: A channel whose function-select bit is 1 (compare) sets its flag on the clock edge at which the counter takes that channel's register value, and the flag is visible together with that counter value.
- R5: On a compare match the pin follows the channel's 2-bit action: 01 inverts it, 10 drives it to 0, 11 drives it to 1.
- R6: With action 00 a match leaves the pin at its last level, and the pin enable is low. The pin enable is high only for a compare channel with a nonzero action.
- R7: Interrupt output n equals flag n ANDed with bit n of the interrupt-enable register.
- R8: Writing the flag register clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R9: With control bit 1 set, a write to a channel register clears that channel's flag. With it clear, such a write leaves the flag unchanged.
- R10: A capture channel (function bit 0) that sees an event pulse stores the counter value present before that clock edge and sets its flag. A capture channel never produces a compare match.
- R11: Under a prescale of 2^p > 1, a match fires once per counter step. A flag that is cleared while the counter still rests on the matching value stays clear.
- R12: Control, function-select, action and enable registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| cap_evt | input | 8 | Per-channel capture event pulses |
| oc_pin | output | 8 | Channel pin levels |
| oc_pin_en | output | 8 | Channel pin drive enables |
| irq | output | 8 | Per-channel interrupt requests |

## Verification
The hardest case to reach is a match that lasts several bus clocks under a slow prescale, where the design must not set the flag again while the counter rests on the matching value. The bench sets a divide-by-4 rate, polls the counter until it lands on the target, and clears the flag while the counter still shows the same value. It then confirms that the flag stays clear, that the pin toggled only once, and that the counter has not yet moved. The exact edge of a match is pinned down by reading the flag one sample before and one sample after the counter reaches the target.

// File: rtl/octmr_pkg.sv
`timescale 1ns/1ps
package octmr_pkg;

  typedef logic [1:0] act_t;

  localparam act_t ACT_NONE = 2'b00;
  localparam act_t ACT_TGL  = 2'b01;
  localparam act_t ACT_LOW  = 2'b10;
  localparam act_t ACT_HIGH = 2'b11;

  localparam int A_CTRL   = 0;
  localparam int A_MODE   = 1;
  localparam int A_ACT_HI = 2;
  localparam int A_ACT_LO = 3;
  localparam int A_IEN    = 4;
  localparam int A_FLAG   = 5;
  localparam int A_COUNT  = 6;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_FCLR_BIT = 1;
  localparam int CTRL_PSC_LSB  = 2;

  // next pin level for an action applied to the current level
  function automatic logic pin_next(input act_t a, input logic cur);
    case (a)
      ACT_TGL:  return ~cur;
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/octmr_timebase.sv
`timescale 1ns/1ps
module octmr_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);

  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;

  // a tick is due when the low p bits of the divider are all ones
  function automatic logic tick_due(input logic [DIV_W-1:0] d,
                                    input logic [PSC_W-1:0] p);
    logic [DIV_W-1:0] m;
    m = DIV_W'((1 << p) - 1);
    return (d & m) == m;
  endfunction

  assign tick    = run && tick_due(div_q, psc);
  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
    end else if (run) begin
      div_q <= div_q + 1'b1;
      if (tick) cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/octmr_channel.sv
`timescale 1ns/1ps
module octmr_channel
  import octmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_cmp,
  input  act_t             act,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             cap_evt,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             fast_clr,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] val,
  output logic             flag,
  output logic             pin,
  output logic             pin_en,
  output logic             hit,
  output logic             cap_hit
);

  // compare against the value the counter is about to take
  assign hit     = tick && is_cmp && (cnt_nxt == val);
  assign cap_hit = cap_evt && !is_cmp;
  assign pin_en  = is_cmp && (act != ACT_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val  <= '0;
      flag <= 1'b0;
      pin  <= 1'b0;
    end else begin
      if (cap_hit)     val <= cnt;
      else if (reg_wr) val <= wdata;

      if (hit || cap_hit)                          flag <= 1'b1;
      else if (flag_clr || (reg_wr && fast_clr))   flag <= 1'b0;

      if (hit) pin <= pin_next(act, pin);
    end
  end

endmodule

// File: rtl/octimer_unit.sv
`timescale 1ns/1ps
module octimer_unit
  import octmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 8,
  parameter int PSC_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] cap_evt,
  output logic [NUM_CH-1:0] oc_pin,
  output logic [NUM_CH-1:0] oc_pin_en,
  output logic [NUM_CH-1:0] irq
);

  localparam int HALF  = NUM_CH / 2;
  localparam int ACT_W = 2 * HALF;
  localparam int SEL_W = ADDR_W - 1;

  logic              run_q, fclr_q;
  logic [PSC_W-1:0]  psc_q;
  logic [NUM_CH-1:0] mode_q, ien_q;
  logic [ACT_W-1:0]  act_hi_q, act_lo_q;
  logic [2*NUM_CH-1:0] act_all;

  logic              tick;
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic [NUM_CH-1:0] hit_vec, cap_vec, flag_vec, flag_clr;
  logic [CNT_W-1:0]  chan_val [NUM_CH];

  logic wr_ctrl, wr_mode, wr_ahi, wr_alo, wr_ien, wr_flag;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_mode = bus_wr && (bus_addr == ADDR_W'(A_MODE));
  assign wr_ahi  = bus_wr && (bus_addr == ADDR_W'(A_ACT_HI));
  assign wr_alo  = bus_wr && (bus_addr == ADDR_W'(A_ACT_LO));
  assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(A_IEN));
  assign wr_flag = bus_wr && (bus_addr == ADDR_W'(A_FLAG));

  assign flag_clr = wr_flag ? bus_wdata[NUM_CH-1:0] : '0;
  assign act_all  = {act_hi_q, act_lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      fclr_q   <= 1'b0;
      psc_q    <= '0;
      mode_q   <= '0;
      ien_q    <= '0;
      act_hi_q <= '0;
      act_lo_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= bus_wdata[CTRL_RUN_BIT];
        fclr_q <= bus_wdata[CTRL_FCLR_BIT];
        psc_q  <= bus_wdata[CTRL_PSC_LSB +: PSC_W];
      end
      if (wr_mode) mode_q   <= bus_wdata[NUM_CH-1:0];
      if (wr_ien)  ien_q    <= bus_wdata[NUM_CH-1:0];
      if (wr_ahi)  act_hi_q <= bus_wdata[ACT_W-1:0];
      if (wr_alo)  act_lo_q <= bus_wdata[ACT_W-1:0];
    end
  end

  octmr_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .psc     (psc_q),
    .tick    (tick),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ch_wr;
    assign ch_wr = bus_wr && bus_addr[ADDR_W-1] && (bus_addr[SEL_W-1:0] == SEL_W'(i));

    octmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_cmp   (mode_q[i]),
      .act      (act_t'(act_all[2*i +: 2])),
      .tick     (tick),
      .cnt      (cnt),
      .cnt_nxt  (cnt_nxt),
      .cap_evt  (cap_evt[i]),
      .reg_wr   (ch_wr),
      .wdata    (bus_wdata),
      .fast_clr (fclr_q),
      .flag_clr (flag_clr[i]),
      .val      (chan_val[i]),
      .flag     (flag_vec[i]),
      .pin      (oc_pin[i]),
      .pin_en   (oc_pin_en[i]),
      .hit      (hit_vec[i]),
      .cap_hit  (cap_vec[i])
    );
  end

  assign irq = flag_vec & ien_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[ADDR_W-1]) begin
      for (int i = 0; i < NUM_CH; i++)
        if (bus_addr[SEL_W-1:0] == SEL_W'(i)) bus_rdata = chan_val[i];
    end else begin
      case (int'(bus_addr))
        A_CTRL: begin
          bus_rdata[CTRL_RUN_BIT]              = run_q;
          bus_rdata[CTRL_FCLR_BIT]             = fclr_q;
          bus_rdata[CTRL_PSC_LSB +: PSC_W]     = psc_q;
        end
        A_MODE:   bus_rdata = CNT_W'(mode_q);
        A_ACT_HI: bus_rdata = CNT_W'(act_hi_q);
        A_ACT_LO: bus_rdata = CNT_W'(act_lo_q);
        A_IEN:    bus_rdata = CNT_W'(ien_q);
        A_FLAG:   bus_rdata = CNT_W'(flag_vec);
        A_COUNT:  bus_rdata = cnt;
        default:  bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/octimer_unit_chk.sv
`timescale 1ns/1ps
module octimer_unit_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [NUM_CH-1:0] hit,
  input logic [NUM_CH-1:0] flags,
  input logic [NUM_CH-1:0] pin
);

  // R2: no step without a tick
  a_r2_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  // R3: each tick advances by one, wrapping
  a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R11: matches happen only on counter steps
  a_r11_hit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |-> tick);

  // R4: every matching channel shows its flag after the edge
  a_r4_flag_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((flags & $past(hit)) == $past(hit)));

  // R6: pins move only on a match
  a_r6_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |=> $stable(pin));

endmodule

bind octimer_unit octimer_unit_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick),
  .cnt   (cnt),
  .hit   (hit_vec),
  .flags (flag_vec),
  .pin   (oc_pin)
);

// File: tb/octimer_unit_test.sv
`timescale 1ns/1ps
module octimer_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  cap_evt = '0;
  logic [7:0]  oc_pin, oc_pin_en, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  octimer_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_evt(cap_evt),
    .oc_pin(oc_pin), .oc_pin_en(oc_pin_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // poll the counter at each falling edge until it equals tgt
  task automatic wait_count(input logic [15:0] tgt, input int guard);
    logic [15:0] c;
    for (int k = 0; k < guard; k++) begin
      @(negedge clk);
      rd(4'd6, c);
      if (c == tgt) return;
    end
    chk("wait_count reached", c, tgt);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reg %0d after reset", a), v, 0);
    end
    chk("R1 pins", oc_pin, 0);
    chk("R1 pin enables", oc_pin_en, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_enable;
    logic [15:0] a, b;
    rd(4'd6, a);
    repeat (20) @(negedge clk);
    rd(4'd6, b);
    chk("R2 counter held while stopped", b, a);
  endtask

  task automatic t_rates;
    logic [15:0] a, b;
    int ps [3] = '{0, 3, 7};
    foreach (ps[k]) begin
      wr(4'd0, 16'(1 | (ps[k] << 2)));
      rd(4'd0, a);
      chk("R12 control readback", a, 16'(1 | (ps[k] << 2)));
      rd(4'd6, a);
      repeat (256) @(negedge clk);
      rd(4'd6, b);
      chk($sformatf("R3 steps at exponent %0d", ps[k]), 16'(b - a), 16'(256 >> ps[k]));
    end
  endtask

  task automatic t_compare;
    logic [15:0] c, v, tgt;
    wr(4'd0, 16'h0001);
    wr(4'd1, 16'h0070);
    wr(4'd2, 16'h003D);     // ch6 set, ch5 set, ch4 toggle
    rd(4'd2, v);
    chk("R12 action readback", v, 16'h003D);
    rd(4'd6, c);
    tgt = c + 16'd40;
    wr(4'd12, tgt); wr(4'd13, tgt); wr(4'd14, tgt);
    wait_count(tgt - 16'd1, 200);
    rd(4'd5, v);
    chk("R4 no flag before match", v, 0);
    chk("R5 pins before match", oc_pin, 0);
    @(negedge clk);
    rd(4'd6, c);
    chk("R4 counter at target", c, tgt);
    rd(4'd5, v);
    chk("R4 flags with target count", v, 16'h0070);
    chk("R5 set and toggle to 1", oc_pin, 8'h70);
    chk("R6 enables for nonzero action", oc_pin_en, 8'h70);
    // interrupt enable and flag clearing
    chk("R7 irq masked", irq, 0);
    wr(4'd4, 16'h0020);
    chk("R7 irq enabled", irq, 8'h20);
    wr(4'd5, 16'h0000);
    rd(4'd5, v);
    chk("R8 zero write keeps flags", v, 16'h0070);
    wr(4'd5, 16'h0020);
    rd(4'd5, v);
    chk("R8 one clears flag", v, 16'h0050);
    chk("R7 irq drops with flag", irq, 0);
    wr(4'd5, 16'h0050);
    // second round
    wr(4'd2, 16'h0021);     // ch6 clear, ch5 none, ch4 toggle
    rd(4'd6, c);
    tgt = c + 16'd40;
    wr(4'd12, tgt); wr(4'd13, tgt); wr(4'd14, tgt);
    wait_count(tgt, 200);
    chk("R5 clear and toggle back", oc_pin, 8'h20);
    chk("R6 action 00 drops enable", oc_pin_en, 8'h50);
    rd(4'd5, v);
    chk("R6 match still flags with action 00", v, 16'h0070);
    // quick clear option
    wr(4'd13, 16'h1234);
    rd(4'd5, v);
    chk("R9 write without quick clear", v, 16'h0070);
    wr(4'd0, 16'h0003);
    wr(4'd13, 16'h1234);
    rd(4'd5, v);
    chk("R9 write with quick clear", v, 16'h0050);
    wr(4'd0, 16'h0001);
    wr(4'd5, 16'h00FF);
    wr(4'd4, 16'h0000);
  endtask

  task automatic t_capture;
    logic [15:0] c, v;
    @(negedge clk);
    rd(4'd6, c);
    cap_evt = 8'h01;
    @(negedge clk);
    cap_evt = 8'h00;
    rd(4'd8, v);
    chk("R10 captured count", v, c);
    rd(4'd5, v);
    chk("R10 capture flag", v, 16'h0001);
    chk("R10 capture channel pin disabled", oc_pin_en[0], 0);
    wr(4'd5, 16'h0001);
    rd(4'd6, c);
    wr(4'd9, c + 16'd6);
    repeat (20) @(negedge clk);
    rd(4'd5, v);
    chk("R10 capture channel never matches", v, 0);
  endtask

  task automatic t_slow;
    logic [15:0] c, v, tgt;
    wr(4'd0, 16'h0009);     // run, divide by 4
    wr(4'd1, 16'h00F0);
    wr(4'd2, 16'h0040);     // ch7 toggle
    rd(4'd6, c);
    tgt = c + 16'd20;
    wr(4'd15, tgt);
    wait_count(tgt, 200);
    rd(4'd5, v);
    chk("R11 flag on slow match", v[7], 1);
    chk("R11 pin toggled once", oc_pin[7], 1);
    wr(4'd5, 16'h0080);
    rd(4'd6, c);
    chk("R11 counter still on target", c, tgt);
    rd(4'd5, v);
    chk("R11 no retrigger while resting", v[7], 0);
    chk("R11 pin not toggled again", oc_pin[7], 1);
  endtask

  task automatic t_wrap;
    logic [15:0] c;
    wr(4'd0, 16'h0001);
    wait_count(16'hFFFF, 70000);
    @(negedge clk);
    rd(4'd6, c);
    chk("R3 wrap to zero", c, 0);
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_rates();
    t_compare();
    t_capture();
    t_slow();
    t_wrap();
    report();
  end

endmodule